// File: doc/BRIEF.md
# Gated Pixel Output Clock Generator

This block drives the pixel clock and the pixel data byte of an image sensor's readout port. It runs on the system clock and produces a pixel clock that moves only while the readout sequencer reports that physical pixels are being scanned. Dummy pixels count as scanned pixels. The clock stays at rest through line blanking. Software picks a low-power divide ratio and an output polarity. The block holds both settings steady while a line is in progress, so a new setting can never shorten a clock level.

The pixel clock is modelled as a flop-driven level that changes once every D system cycles, where D is the divide ratio. Each pixel therefore spans 2·D system cycles. The data byte changes only on the clock edge that returns to the rest level, so a receiver samples it safely on the edge that leaves the rest level. While the clock is at rest, the data register follows its input, so the first pixel of a line is already valid before the first sampling edge.

Top module: `pixclk_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `pix_clk` and `pix_data` are 0 whatever the other inputs are.
- R2: The ratio D is selected by `div_sel`: 2'b00 gives D = 1, 2'b01 gives D = 2, 2'b10 gives D = 4, and the reserved code 2'b11 gives D = 1. While `line_active` is high, each level of `pix_clk` lasts exactly D system cycles.
- R3: Starting from rest, `pix_clk` first leaves its rest level on the D-th rising edge of `clk`, counting the first edge at which `line_active` is sampled high as edge 1.
- R4: When `line_active` is low and `pix_clk` is at rest, `pix_clk` keeps its rest level. The only exception is a polarity update under R6.
- R5: If `line_active` is sampled low while `pix_clk` is away from rest, the current level still lasts its full D cycles. The clock then returns to rest and stops. If the clock is already at rest, it stops at once.
- R6: The rest level of `pix_clk` equals the captured polarity: low for `invert` = 0, high for `invert` = 1. `div_sel` and `invert` are captured on every edge at which `line_active` is low and `pix_clk` is at rest. The new rest level shows after that edge.
- R7: Values on `div_sel` and `invert` on any other edge have no effect on `pix_clk` or `pix_data`.
- R8: While the clock runs, `pix_data` loads `data_in` only on the edge where `pix_clk` returns to rest. That edge is falling when non-inverted and rising when inverted. At all other edges `pix_data` holds.
- R9: On every edge at which `line_active` is low and `pix_clk` is at rest, `pix_data` loads `data_in`. The first pixel of a line is therefore the value present at the last such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_sel | input | 2 | Low-power divide select (R2 encoding) |
| invert | input | 1 | Output polarity select; also the rest level |
| line_active | input | 1 | High while the sequencer scans physical pixels |
| data_in | input | DW | Pixel byte from the readout path |
| pix_clk | output | 1 | Gated, divided, optionally inverted pixel clock |
| pix_data | output | DW | Registered pixel byte, launched on the return-to-rest edge |

## Verification
Two events can meet on one edge: the start of blanking and the last half-period of a pixel. When `line_active` drops while the clock is away from rest, the clock must finish that level and launch the next byte on the same edge that parks it. Only after that edge may a new configuration be captured. The sweep drives every divide code and both polarities over line lengths from 1 to 9 cycles, so blanking falls both in mid-level and on a level boundary. Every second line also drives inverted settings for as long as the line runs, and the output is compared cycle by cycle against waveforms computed from D, the line length and the polarity.

// File: rtl/pixclk_pkg.sv
// Package: shared constants and the divide-code decoder for the pixel
// clock generator. Assumes at most a divide by 4 in low-power mode.
package pixclk_pkg;

    localparam int unsigned MAX_DIV = 4;
    localparam int unsigned DIV_CW  = $clog2(MAX_DIV);

    typedef enum logic [1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_RSV = 2'b11
    } div_code_e;

    // Number of system cycles per pixel-clock level for a divide code.
    function automatic int unsigned div_cycles(input logic [1:0] code);
        case (div_code_e'(code))
            DIV_BY2: return 2;
            DIV_BY4: return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/pixclk_cfg.sv
// Module: configuration shadow registers. Captures the divide code and the
// polarity only when the caller asserts load (clock at rest and no line
// active), so settings never change in the middle of a clock level.
// Assumes load is a synchronous qualifier in the clk domain.
module pixclk_cfg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] div_sel,
    input  logic       invert,
    output logic [1:0] div_q,
    output logic       inv_q
);

    // Shadow capture of divide code and polarity while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 2'b00;
            inv_q <= 1'b0;
        end else if (load) begin
            div_q <= div_sel;
            inv_q <= invert;
        end
    end

endmodule

// File: rtl/pixclk_div.sv
// Module: divider and phase flop. While a line is active, or the phase is
// away from rest, it counts D cycles per level and flips the phase. It
// flags the return-to-rest edge as a launch. Assumes div_q is stable
// whenever the counter runs.
module pixclk_div
    import pixclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_active,
    input  logic [1:0] div_q,
    output logic       phase,
    output logic       launch,
    output logic       idle
);

    localparam int unsigned CW = (DIV_CW > 0) ? DIV_CW : 1;

    logic [CW-1:0] cnt;
    logic          running;
    logic          tick;
    logic [CW-1:0] last;

    // Decode terminal count and run condition.
    always_comb begin
        last    = CW'(div_cycles(div_q) - 1);
        running = line_active | phase;
        tick    = running && (cnt == last);
        launch  = tick && phase;
        idle    = !running;
    end

    // Level counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!running) begin
            cnt   <= '0;
        end else if (tick) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pixclk_launch.sv
// Module: pixel data register. Loads the incoming byte whenever the
// clock is parked (idle) or on a launch edge, and holds it otherwise.
// Assumes idle and launch never both indicate a running mid-level.
module pixclk_launch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          launch,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] pix_data
);

    // Data launch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_data <= '0;
        end else if (idle || launch) begin
            pix_data <= data_in;
        end
    end

endmodule

// File: rtl/pixclk_gen.sv
// Module: top of the gated pixel clock generator. Ties the config shadow,
// divider and data register together and forms the output clock as the
// phase flop XOR the captured polarity. Because polarity only changes while
// the phase is at rest, the two flops never switch on the same edge.
// Assumes line_active comes synchronously from the readout sequencer.
module pixclk_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    div_sel,
    input  logic          invert,
    input  logic          line_active,
    input  logic [DW-1:0] data_in,
    output logic          pix_clk,
    output logic [DW-1:0] pix_data
);

    logic [1:0] div_q;
    logic       inv_q;
    logic       phase;
    logic       launch;
    logic       idle;

    pixclk_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (idle),
        .div_sel (div_sel),
        .invert  (invert),
        .div_q   (div_q),
        .inv_q   (inv_q)
    );

    pixclk_div u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_active (line_active),
        .div_q       (div_q),
        .phase       (phase),
        .launch      (launch),
        .idle        (idle)
    );

    pixclk_launch #(.DW(DW)) u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .launch   (launch),
        .data_in  (data_in),
        .pix_data (pix_data)
    );

    // Output polarity.
    always_comb begin
        pix_clk = phase ^ inv_q;
    end

endmodule

// File: rtl/pixclk_gen_chk.sv
// Module: assertion checker for pixclk_gen, attached through bind. Tracks
// how long pix_clk has held its level, so that no level is shorter than
// the divide ratio.
module pixclk_gen_chk
    import pixclk_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_active,
    input logic          phase,
    input logic          launch,
    input logic          pix_clk,
    input logic          inv_q,
    input logic [1:0]    div_q,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] pix_data
);

    logic       prev_clk;
    logic       prev_inv;
    logic [3:0] held;

    // Run-length tracker for the output clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_clk <= 1'b0;
            prev_inv <= 1'b0;
            held     <= 4'hF;
        end else begin
            prev_clk <= pix_clk;
            prev_inv <= inv_q;
            if (pix_clk != prev_clk) held <= 4'd1;
            else if (held != 4'hF)   held <= held + 4'd1;
        end
    end

    AST_MIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_clk != prev_clk && inv_q == prev_inv) |-> (int'(held) >= int'(div_cycles(div_q)))); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (line_active || phase) |=> ($stable(inv_q) && $stable(div_q))); // R7

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_active || phase) && !launch) |=> $stable(pix_data)); // R8

    AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_active && pix_clk == inv_q) |=> (pix_clk == inv_q)); // R4

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_active && !phase) |=> (pix_data == $past(data_in))); // R9

endmodule

bind pixclk_gen pixclk_gen_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_active (line_active),
    .phase       (phase),
    .launch      (launch),
    .pix_clk     (pix_clk),
    .inv_q       (inv_q),
    .div_q       (div_q),
    .data_in     (data_in),
    .pix_data    (pix_data)
);

// File: tb/pixclk_gen_test.sv
// Bench: sweeps every divide code, both polarities and line lengths 1..9,
// with and without illegal mid-line config changes, and compares pix_clk
// and pix_data every cycle against arithmetically derived waveforms.
module pixclk_gen_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    div_sel = 2'b00;
    logic          invert = 1'b0;
    logic          line_active = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          pix_clk;
    logic [DW-1:0] pix_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pixclk_gen #(.DW(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .div_sel     (div_sel),
        .invert      (invert),
        .line_active (line_active),
        .data_in     (data_in),
        .pix_clk     (pix_clk),
        .pix_data    (pix_data)
    );

    function automatic int dcyc(input logic [1:0] s);
        case (s)
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [DW-1:0] pat(input int k, input int ln);
        return DW'((k + 5) * 29 + ln * 13);
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One line: 3 idle edges, L active edges, then drain and 2 idle edges.
    task automatic run_line(input logic [1:0] d, input logic inv, input int L,
                            input bit junk, input int ln);
        int D, t0, tf, kend, m, mb;
        bit ph, is_idle, is_launch, jk;
        logic [DW-1:0] exp_d;
        string ctag, dtag;
        D = dcyc(d);
        t0 = L / D;
        tf = t0 + (t0 % 2);
        kend = (L - 1 > tf * D - 1) ? L - 1 : tf * D - 1;
        exp_d = '0;
        for (int k = -3; k <= kend + 2; k++) begin
            jk = junk && k >= 0 && k <= kend;
            line_active = (k >= 0 && k < L);
            div_sel = jk ? ~d : d;
            invert  = jk ? ~inv : inv;
            data_in = pat(k, ln);
            @(posedge clk);
            @(negedge clk);
            if (k < 0) begin
                ph = 1'b0;
                is_idle = 1'b1;
                is_launch = 1'b0;
            end else begin
                m = (k + 1) / D;
                if (m > tf) m = tf;
                ph = (m % 2) == 1;
                mb = k / D;
                if (mb > tf) mb = tf;
                is_idle = (k >= L) && (mb % 2 == 0);
                is_launch = ((k + 1) % D == 0) && ((k + 1) / D <= tf)
                            && (((k + 1) / D) % 2 == 0);
            end
            if (is_idle || is_launch) exp_d = pat(k, ln);
            if (jk)                        ctag = "R7";
            else if (k < 0)                ctag = "R6";
            else if (k < L && k <= D - 1)  ctag = "R3";
            else if (k < L)                ctag = "R2";
            else if (k <= kend)            ctag = "R5";
            else                           ctag = "R4";
            dtag = is_idle ? "R9" : "R8";
            check(ctag, int'(pix_clk), int'(ph ^ inv),
                  $sformatf("pix_clk d=%0d inv=%0d L=%0d k=%0d", d, inv, L, k));
            check(dtag, int'(pix_data), int'(exp_d),
                  $sformatf("pix_data d=%0d inv=%0d L=%0d k=%0d", d, inv, L, k));
        end
    endtask

    initial begin
        int ln;
        // R1: reset dominates active inputs.
        invert = 1'b1;
        line_active = 1'b1;
        data_in = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(pix_clk), 0, "pix_clk in reset");
        check("R1", int'(pix_data), 0, "pix_data in reset");
        rst_n = 1'b1;
        line_active = 1'b0;
        invert = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", int'(pix_clk), 0, "pix_clk after release");
        ln = 0;
        for (int d = 0; d < 4; d++) begin
            for (int inv = 0; inv < 2; inv++) begin
                for (int L = 1; L <= 9; L++) begin
                    for (int j = 0; j < 2; j++) begin
                        run_line(2'(d), 1'(inv), L, j[0], ln);
                        ln++;
                    end
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule